// File: doc/BRIEF.md
# Parking Two-Master Bus Arbiter

This arbiter shares one address bus between two masters: a processor and a cache controller. By default the processor is parked. Its grant is held asserted whether or not it wants the bus, so it can start a transfer with no arbitration delay. The processor has no request input. The controller takes the bus only when it has invalidate work.

Each invalidate request is a one-cycle pulse on `inv_req_i`. A saturating counter holds the pending requests. When work is pending, the arbiter drops the processor grant. If the processor still holds address-busy, the arbiter asks it to retry. Once the bus is idle, the arbiter drives the controller's address-busy and a one-cycle transfer-start. The processor grant comes back one cycle later, but the processor only sees a qualified grant (grant high, address-busy low) after the controller's transfer ends. Requests that arrive while the controller owns the bus are serviced one after another before the processor is parked again.

A strap input selects whether the arbiter is active. The strap is captured once, on the first clock edge after reset is released. When it is off, the grant pin's output enable stays low and every arbiter output stays inactive.

Top module: `park_arb`

## Requirements
- R1: The strap is captured on the first rising clock edge after `rst_ni` is released. From the following cycle, a captured value of 1 drives `pgrant_oe_o`=1 and `pgrant_o`=1 with no request pending, and `pgrant_oe_o` keeps that value until the next reset.
- R2: If the strap is captured as 0, then `pgrant_oe_o`, `pgrant_o`, `retry_o`, `ctl_abb_o` and `ctl_ts_o` all stay 0 until the next reset. This holds whatever is driven on `inv_req_i`, `proc_abb_i`, `ctl_done_i` or the strap.
- R3: While no request is pending, `pgrant_o` stays 1 and `retry_o` stays 0, whatever `proc_abb_i` does.
- R4: A request pulse sampled at edge k makes `pgrant_o` fall after edge k+1.
- R5: While the processor grant is withdrawn for a takeover, `retry_o` follows `proc_abb_i`. `ctl_ts_o` rises only after an edge at which `proc_abb_i` was sampled low.
- R6: `ctl_ts_o` is high for exactly one cycle, with `ctl_abb_o`=1 and `pgrant_o`=0 in that cycle.
- R7: In the cycle after `ctl_ts_o`, `pgrant_o` is 1 again. `ctl_abb_o` stays 1 until the edge that samples `ctl_done_i`=1. The next cycle shows the qualified grant (`pgrant_o`=1, `ctl_abb_o`=0) when no further request is pending.
- R8: Requests sampled while the controller owns the bus are queued, with at most 2^PEND_W-1 pending (3 by default); further requests are dropped. After the current transfer ends, each queued request gets its own takeover: one cycle with the grant withdrawn, one start cycle, then ownership.
- R9: `ctl_done_i` has no effect while the controller does not own the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_arb_en_i | input | 1 | Arbiter enable strap, captured once after reset |
| inv_req_i | input | 1 | One-cycle pulse: controller has one invalidate to perform |
| proc_abb_i | input | 1 | Address-busy as driven by the processor |
| ctl_done_i | input | 1 | Last cycle of the controller's transfer |
| pgrant_o | output | 1 | Grant to the processor |
| pgrant_oe_o | output | 1 | Output enable of the grant pin (0 makes it an input) |
| retry_o | output | 1 | Retry request to the processor's current transfer |
| ctl_abb_o | output | 1 | Address-busy driven on behalf of the controller |
| ctl_ts_o | output | 1 | Transfer-start pulse for the controller |

## Verification
The takeover is swept over the processor holding the bus for 0 to 3 cycles after the grant drops, controller transfers of 1 to 5 cycles, and 0 up to one less than the transfer length of extra requests sampled during ownership. The busy-length sweep tells an immediate start apart from a start held back behind retry. The ownership length shows that address-busy follows the done input rather than a fixed count. The queued counts below and above the counter's capacity separate back-to-back servicing from saturation. Separate runs toggle processor address-busy and pulse done while parked, and reset with each strap value, to check parking, ignored inputs and the disabled mode.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;
  typedef enum logic [1:0] {
    ST_PARK   = 2'd0,
    ST_REVOKE = 2'd1,
    ST_START  = 2'd2,
    ST_OWN    = 2'd3
  } arb_state_e;
endpackage

// File: rtl/park_arb_strap.sv
module park_arb_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic arb_on_o
);
  logic cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= 1'b0;
      arb_on_o <= 1'b0;
    end else if (!cap_q) begin
      cap_q    <= 1'b1;
      arb_on_o <= strap_i;
    end
  end
endmodule

// File: rtl/park_arb_pend.sv
module park_arb_pend #(
  parameter int unsigned PEND_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  logic [PEND_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != PEND_MAX) cnt_q <= cnt_q + PEND_ONE;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - PEND_ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pend_o = |cnt_q;
endmodule

// File: rtl/park_arb_fsm.sv
module park_arb_fsm
  import park_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pend_i,
  input  logic proc_abb_i,
  input  logic done_i,
  output logic take_o,
  output logic pgrant_o,
  output logic retry_o,
  output logic abb_o,
  output logic ts_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PARK:   if (pend_i) state_d = ST_REVOKE;
      ST_REVOKE: if (!proc_abb_i) state_d = ST_START;
      ST_START:  state_d = ST_OWN;
      ST_OWN:    if (done_i) state_d = pend_i ? ST_REVOKE : ST_PARK;
      default:   state_d = ST_PARK;
    endcase
    if (!en_i) state_d = ST_PARK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PARK;
    else         state_q <= state_d;
  end

  // processor re-parked from the cycle after transfer-start
  assign pgrant_o = en_i && (state_q == ST_PARK || state_q == ST_OWN);
  assign retry_o  = en_i && (state_q == ST_REVOKE) && proc_abb_i;
  assign take_o   = en_i && (state_q == ST_REVOKE) && !proc_abb_i;
  assign abb_o    = en_i && (state_q == ST_START || state_q == ST_OWN);
  assign ts_o     = en_i && (state_q == ST_START);
endmodule

// File: rtl/park_arb.sv
module park_arb #(
  parameter int unsigned PEND_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_arb_en_i,
  input  logic inv_req_i,
  input  logic proc_abb_i,
  input  logic ctl_done_i,
  output logic pgrant_o,
  output logic pgrant_oe_o,
  output logic retry_o,
  output logic ctl_abb_o,
  output logic ctl_ts_o
);
  logic arb_on, pend, take;

  park_arb_strap u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_arb_en_i),
    .arb_on_o (arb_on)
  );

  park_arb_pend #(.PEND_W(PEND_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (arb_on),
    .inc_i  (inv_req_i),
    .dec_i  (take),
    .pend_o (pend)
  );

  park_arb_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (arb_on),
    .pend_i     (pend),
    .proc_abb_i (proc_abb_i),
    .done_i     (ctl_done_i),
    .take_o     (take),
    .pgrant_o   (pgrant_o),
    .retry_o    (retry_o),
    .abb_o      (ctl_abb_o),
    .ts_o       (ctl_ts_o)
  );

  assign pgrant_oe_o = arb_on;
endmodule

// File: rtl/park_arb_chk.sv
module park_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic proc_abb_i,
  input logic ctl_done_i,
  input logic pgrant_o,
  input logic pgrant_oe_o,
  input logic retry_o,
  input logic ctl_abb_o,
  input logic ctl_ts_o
);
  logic idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= 1'b0;
    else         idle_q <= pgrant_oe_o && !pgrant_o && !proc_abb_i && !ctl_abb_o;
  end

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgrant_oe_o |=> pgrant_oe_o); // R1
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgrant_oe_o |-> !pgrant_o && !retry_o && !ctl_abb_o && !ctl_ts_o); // R2
  AST_RETRY_REVOKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> proc_abb_i && !pgrant_o); // R5
  AST_TS_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ts_o |-> idle_q); // R5
  AST_TS_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ts_o |-> ctl_abb_o && !pgrant_o); // R6
  AST_TS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ts_o |=> !ctl_ts_o); // R6
  AST_REPARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ts_o |=> pgrant_o && ctl_abb_o); // R7
  AST_ABB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_abb_o && !ctl_done_i |=> ctl_abb_o); // R7
  AST_ABB_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_abb_o) |-> ctl_ts_o); // R6
endmodule

bind park_arb park_arb_chk u_chk (.*);

// File: tb/park_arb_bench.sv
module park_arb_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strap = 1'b0, inv_req = 1'b0, proc_abb = 1'b0, done = 1'b0;
  logic pgrant, pgrant_oe, retry, ctl_abb, ctl_ts;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  park_arb #(.PEND_W(2)) u_park_arb (
    .clk_i(clk), .rst_ni(rst_ni), .strap_arb_en_i(strap), .inv_req_i(inv_req),
    .proc_abb_i(proc_abb), .ctl_done_i(done), .pgrant_o(pgrant),
    .pgrant_oe_o(pgrant_oe), .retry_o(retry), .ctl_abb_o(ctl_abb), .ctl_ts_o(ctl_ts)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input logic g, input logic r, input logic a, input logic t);
    chk({tag, " grant"}, pgrant, g);
    chk({tag, " retry"}, retry, r);
    chk({tag, " abb"}, ctl_abb, a);
    chk({tag, " ts"}, ctl_ts, t);
  endtask

  task automatic do_reset(input logic s);
    rst_ni = 1'b0; strap = s; inv_req = 1'b0; proc_abb = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R1 oe before capture", pgrant_oe, 1'b0);
    @(negedge clk);
    chk("R1 oe after capture", pgrant_oe, s);
    outs("R1 idle", s, 1'b0, 1'b0, 1'b0);
  endtask

  // B: processor busy cycles after revoke, W: ownership cycles, Q: requests queued during ownership
  task automatic takeover(input int b, input int w, input int q);
    int served;
    served = (q > 3) ? 3 : q;
    inv_req = 1'b1; proc_abb = (b > 0);
    #1 chk("R3 grant before pend", pgrant, 1'b1);
    @(negedge clk);
    inv_req = 1'b0;
    outs("R4 one edge after req", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    outs("R4 revoke", 1'b0, (b > 0), 1'b0, 1'b0);
    if (b > 0) begin
      for (int i = 1; i < b; i++) begin
        @(negedge clk);
        outs("R5 held by retry", 1'b0, 1'b1, 1'b0, 1'b0);
      end
      proc_abb = 1'b0;
      #1 chk("R5 retry follows busy", retry, 1'b0);
    end
    @(negedge clk);
    outs("R6 start", 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    for (int i = 0; i < w; i++) begin
      outs("R7 own", 1'b1, 1'b0, 1'b1, 1'b0);
      inv_req = (i < q);
      done = (i == w - 1);
      @(negedge clk);
      inv_req = 1'b0; done = 1'b0;
    end
    for (int k = 0; k < served; k++) begin
      outs("R8 queued revoke", 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      outs("R8 queued start", 1'b0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      outs("R8 queued own", 1'b1, 1'b0, 1'b1, 1'b0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    outs("R7 qualified grant", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    outs("R8 no extra service", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) begin
      inv_req = i[0]; proc_abb = i[1]; done = i[2]; strap = ~strap;
      @(negedge clk);
      chk("R2 oe off", pgrant_oe, 1'b0);
      outs("R2 off", 1'b0, 1'b0, 1'b0, 1'b0);
    end
    do_reset(1'b1);
    for (int i = 0; i < 8; i++) begin
      proc_abb = i[0] ^ i[2]; done = i[1];
      strap = i[0];
      @(negedge clk);
      outs("R3 R9 parked", 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R1 oe held", pgrant_oe, 1'b1);
    end
    proc_abb = 1'b0; done = 1'b0;
    @(negedge clk);
    for (int b = 0; b < 4; b++)
      for (int w = 1; w <= 5; w++)
        for (int q = 0; q < w; q++)
          takeover(b, w, q);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule